// File: doc/BRIEF.md
# Dual-Mode Codec Serial Port

This block is the serial side of a voice-band codec. It exchanges 8-bit companded samples with a DSP over a bit clock, a frame strobe and a pair of data lines. On the chip side it offers a parallel byte interface. Transmit bytes are taken with a valid/ready handshake, and each received byte comes out with a one-cycle valid pulse.

A mode input picks the timing role, and it may change while the block runs. As timing master, the port divides its system clock to make the bit clock. It drives that clock out and raises a frame strobe once per frame. As timing slave, the port disables its clock driver and synchronises the external bit clock and frame strobe into the system clock domain. It then follows them. In slave mode, every bit-clock period is measured in system clocks and compared with the nominal rate named by a two-bit rate select. A mismatch raises an error flag.

Top module: `codec_serial_port`

## Requirements
- R1: With `mode_master` high, `bclk_oe` is high and `bclk_out` has a period of MASTER_DIV system clocks at 50 % duty. With `mode_master` low, `bclk_oe` is low and `bclk_out` is low from the next cycle on.
- R2: In master mode a frame starts every FRAME_SLOTS bit-clock periods. With `long_frame` low, `fs_out` is high for exactly one bit period, the slot just before the first data bit.
- R3: With `long_frame` high, `fs_out` stays high for nine bit periods: the lead slot plus all eight data slots.
- R4: The transmit byte is shifted out MSB first on `sd_out`. Each bit changes on a bit-clock rising edge, over the eight slots that follow the strobe slot. `sd_out` is low at every other time.
- R5: Incoming data is sampled on bit-clock falling edges, MSB first, in the same eight slots. The byte appears on `rx_data` with a one-cycle `rx_valid` pulse, and `rx_mu` copies `law_mu` (1 = mu-law, 0 = A-law) at that moment.
- R6: `tx_ready` is high while the one-byte holding register is free. A byte accepted with `tx_valid` is sent in the next frame to start. A frame that finds no new byte resends the previous one, which is 0x00 after reset.
- R7: In master mode `fs_in` has no effect on framing or data. In slave mode `fs_out` is low.
- R8: In slave mode a frame starts when `fs_in` is high at a falling `bclk_in` edge after being low at the previous falling edge. Data then occupies the next eight bit periods, in both frame formats.
- R9: In slave mode each `bclk_in` period is measured in system clocks. The nominal values are: `rate_sel` 00 = 8×MASTER_DIV, 01 = 2×MASTER_DIV, 10 = MASTER_DIV. Code 11 is reserved and always counts as a mismatch. After each measured period, `rate_err` shows whether that period missed nominal by more than RATE_TOL. `rate_err` is low in master mode.
- R10: A change of `mode_master` abandons the frame in progress. `sd_out` goes low and no byte is delivered for that frame.
- R11: While `rst_n` is low, `sd_out`, `fs_out`, `rx_valid` and `rate_err` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master | input | 1 | 1 = timing master, 0 = timing slave |
| rate_sel | input | 2 | Declared nominal slave bit-clock rate |
| long_frame | input | 1 | Frame strobe format: 0 = one-bit strobe, 1 = strobe over the data bits |
| law_mu | input | 1 | Companding law flag: 1 = mu-law, 0 = A-law |
| bclk_in | input | 1 | External bit clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Output enable for the bit clock driver |
| fs_in | input | 1 | External frame strobe (slave mode) |
| fs_out | output | 1 | Generated frame strobe (master mode) |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_data` |
| rx_mu | output | 1 | Law flag attached to the received byte |
| rate_err | output | 1 | Slave bit-clock period disagrees with `rate_sel` |

## Verification
A slot counter that has drifted in master mode shows up within one frame, as a strobe that is too early, too late or the wrong width. A frame period other than FRAME_SLOTS bit clocks shows when the next frame starts. A bad shift or bit counter corrupts the byte on `sd_out`, or leaves the line high past the eighth slot. It also corrupts `rx_data` at the `rx_valid` pulse about one system clock after the last falling edge. A holding register that is not cleared or loaded correctly appears at the next frame, either as a stale resend or as a stuck-low `tx_ready`. A wrong nominal in the rate monitor flips `rate_err` on the second measured bit clock after the slave clock starts.

// File: rtl/csp_pkg.sv
// Package: shared types for the dual-mode codec serial port.
// Assumes: one system clock domain; bit-clock activity reaches the frame
// engine as single-cycle event strobes.
package csp_pkg;

    // Declared nominal slave bit-clock rate.
    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,   // 256 kHz class
        RATE_MID  = 2'b01,   // 1.024 MHz class
        RATE_FAST = 2'b10,   // 2.048 MHz class
        RATE_RSVD = 2'b11
    } rate_sel_e;

    // Per-cycle bit-clock events seen by the frame engine.
    typedef struct packed {
        logic rise;    // bit-clock rising edge: drive next tx bit
        logic fall;    // bit-clock falling edge: sample rx bit
        logic start;   // this falling edge closes the strobe slot
        logic sd;      // serial input value aligned with the fall event
    } bit_evt_t;

endpackage

// File: rtl/csp_master_timing.sv
// Module: csp_master_timing
// Makes the bit clock, the slot count and the frame strobe when the port is
// timing master.
// Assumes: MASTER_DIV is even and at least 4, and FRAME_SLOTS exceeds
// WORD_BITS + 1. While en is low, all state is held at its idle value, so a
// new master phase always opens with the strobe slot.
module csp_master_timing
    import csp_pkg::*;
#(
    parameter int MASTER_DIV  = 4,
    parameter int FRAME_SLOTS = 256,
    parameter int WORD_BITS   = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     long_frame,
    input  logic     sd_raw,
    output logic     bclk_q,
    output logic     fs_q,
    output bit_evt_t evt
);
    localparam int HALF = MASTER_DIV / 2;
    localparam int DW   = $clog2(MASTER_DIV);
    localparam int SW   = $clog2(FRAME_SLOTS);
    localparam logic [DW-1:0] RISE_AT   = DW'(HALF - 1);
    localparam logic [DW-1:0] FALL_AT   = DW'(MASTER_DIV - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME_SLOTS - 1);
    localparam logic [SW-1:0] LONG_LAST = SW'(WORD_BITS);

    logic [DW-1:0] div_cnt;
    logic [SW-1:0] slot;
    logic [SW-1:0] slot_nx;
    logic          rise_now;
    logic          fall_now;

    // Edge decode and next slot index.
    always_comb begin
        rise_now = en && (div_cnt == RISE_AT);
        fall_now = en && (div_cnt == FALL_AT);
        slot_nx  = (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end

    // System clock divider: counts out one bit-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
        end else if (div_cnt == FALL_AT) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Bit clock level: high for the second half of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bclk_q <= 1'b0;
        end else if (rise_now) begin
            bclk_q <= 1'b1;
        end else if (fall_now) begin
            bclk_q <= 1'b0;
        end
    end

    // Slot counter and strobe; the first rise after enable enters slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            slot <= LAST_SLOT;
            fs_q <= 1'b0;
        end else if (rise_now) begin
            slot <= slot_nx;
            fs_q <= (slot_nx == '0) || (long_frame && (slot_nx <= LONG_LAST));
        end
    end

    // Event bundle for the frame engine.
    always_comb begin
        evt.rise  = rise_now;
        evt.fall  = fall_now;
        evt.start = fall_now && (slot == '0);
        evt.sd    = sd_raw;
    end

endmodule

// File: rtl/csp_slave_timing.sv
// Module: csp_slave_timing
// Brings the external bit clock, frame strobe and serial data into the system
// clock domain and derives edge and frame-start events from them.
// Assumes: each bclk_in level lasts at least two system clocks. The three
// inputs pass through synchronisers of equal depth, so they stay aligned.
module csp_slave_timing
    import csp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     bclk_in,
    input  logic     fs_in,
    input  logic     sd_in,
    output bit_evt_t evt
);
    // Bit order inside each synchroniser stage.
    localparam int B_CLK = 2;
    localparam int B_FS  = 1;
    localparam int B_SD  = 0;

    logic [SYNC_STAGES-1:0][2:0] stg;
    logic [2:0] synced;
    logic       bclk_p;
    logic       fs_prev;
    logic       rise_now;
    logic       fall_now;

    assign synced = stg[SYNC_STAGES-1];

    // Synchroniser shift chain; the newest sample enters stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[SYNC_STAGES-2:0], {bclk_in, fs_in, sd_in}};
        end
    end

    // Previous synchronised bit-clock level, kept even when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_p <= 1'b0;
        end else begin
            bclk_p <= synced[B_CLK];
        end
    end

    // Edge detection on the synchronised bit clock.
    always_comb begin
        rise_now = en && synced[B_CLK] && !bclk_p;
        fall_now = en && !synced[B_CLK] && bclk_p;
    end

    // Strobe level seen at the previous falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            fs_prev <= 1'b0;
        end else if (fall_now) begin
            fs_prev <= synced[B_FS];
        end
    end

    // Event bundle for the frame engine.
    always_comb begin
        evt.rise  = rise_now;
        evt.fall  = fall_now;
        evt.start = fall_now && synced[B_FS] && !fs_prev;
        evt.sd    = synced[B_SD];
    end

endmodule

// File: rtl/csp_rate_mon.sv
// Module: csp_rate_mon
// Measures each slave bit-clock period in system clocks and compares it with
// the nominal period named by the rate select.
// Assumes: a rise event marks each period. The first rise after enable only
// starts a measurement. The flag reflects the most recent period.
module csp_rate_mon
    import csp_pkg::*;
#(
    parameter int MASTER_DIV = 4,
    parameter int RATE_TOL   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rise,
    input  logic [1:0] rate_sel,
    output logic       rate_err
);
    localparam int NOM_FAST = MASTER_DIV;
    localparam int NOM_MID  = 2 * MASTER_DIV;
    localparam int NOM_SLOW = 8 * MASTER_DIV;
    localparam int CNT_MAX  = NOM_SLOW + RATE_TOL + 1;
    localparam int CW       = $clog2(CNT_MAX + 1);

    logic [CW-1:0] per_cnt;
    logic          have_ref;
    logic          off_nom;

    // Mismatch between a measured period and the declared nominal.
    function automatic logic period_off(input logic [CW-1:0] meas, input rate_sel_e sel);
        int nom;
        int m;
        m = int'(meas);
        case (sel)
            RATE_SLOW: nom = NOM_SLOW;
            RATE_MID:  nom = NOM_MID;
            RATE_FAST: nom = NOM_FAST;
            default:   return 1'b1;
        endcase
        return (m > nom + RATE_TOL) || (m + RATE_TOL < nom);
    endfunction

    assign off_nom = period_off(per_cnt, rate_sel_e'(rate_sel));

    // Period counter, reference flag and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            per_cnt  <= '0;
            have_ref <= 1'b0;
            rate_err <= 1'b0;
        end else if (rise) begin
            per_cnt  <= CW'(1);
            have_ref <= 1'b1;
            if (have_ref) begin
                rate_err <= off_nom;
            end
        end else if (per_cnt != CW'(CNT_MAX)) begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/csp_frame_engine.sv
// Module: csp_frame_engine
// Shifts one word out and one word in per frame, driven by bit-clock events.
// It also holds the transmit byte that was offered on the parallel side.
// Assumes: rise and fall never arrive in the same cycle. A start event lands
// on the falling edge of the strobe slot. abort is a one-cycle pulse on a
// role change.
module csp_frame_engine
    import csp_pkg::*;
#(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bit_evt_t             evt,
    input  logic                 abort,
    input  logic                 law_mu,
    input  logic [WORD_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [WORD_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_mu,
    output logic                 sd_out
);
    localparam int CW = $clog2(WORD_BITS + 1);
    localparam logic [CW-1:0] TX_DONE = CW'(WORD_BITS);
    localparam logic [CW-1:0] RX_LAST = CW'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] tx_buf;
    logic                 tx_pend;
    logic [WORD_BITS-1:0] tx_sh;
    logic [CW-1:0]        tx_cnt;
    logic                 tx_busy;
    logic [WORD_BITS-1:0] rx_sh;
    logic [CW-1:0]        rx_cnt;
    logic                 rx_busy;
    logic                 take;

    assign take     = tx_valid && !tx_pend;
    assign tx_ready = !tx_pend;

    // Holding register: a new byte wins over the release caused by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_pend <= 1'b0;
        end else begin
            if (evt.start && !abort) begin
                tx_pend <= 1'b0;
            end
            if (take) begin
                tx_buf  <= tx_data;
                tx_pend <= 1'b1;
            end
        end
    end

    // Transmit shifter: loads at frame start, one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            tx_sh   <= '0;
            tx_cnt  <= '0;
            tx_busy <= 1'b0;
            sd_out  <= 1'b0;
        end else if (evt.start) begin
            tx_sh   <= tx_buf;
            tx_cnt  <= '0;
            tx_busy <= 1'b1;
        end else if (evt.rise && tx_busy) begin
            if (tx_cnt != TX_DONE) begin
                sd_out <= tx_sh[WORD_BITS-1];
                tx_sh  <= {tx_sh[WORD_BITS-2:0], 1'b0};
                tx_cnt <= tx_cnt + 1'b1;
            end else begin
                sd_out  <= 1'b0;
                tx_busy <= 1'b0;
            end
        end
    end

    // Receive shifter: one bit per falling edge after the strobe slot.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            rx_sh   <= '0;
            rx_cnt  <= '0;
            rx_busy <= 1'b0;
        end else if (evt.start) begin
            rx_cnt  <= '0;
            rx_busy <= 1'b1;
        end else if (evt.fall && rx_busy) begin
            rx_sh  <= {rx_sh[WORD_BITS-2:0], evt.sd};
            rx_cnt <= rx_cnt + 1'b1;
            if (rx_cnt == RX_LAST) begin
                rx_busy <= 1'b0;
            end
        end
    end

    // Parallel output: word, law flag and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_mu    <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!abort && !evt.start && evt.fall && rx_busy && (rx_cnt == RX_LAST)) begin
                rx_data  <= {rx_sh[WORD_BITS-2:0], evt.sd};
                rx_mu    <= law_mu;
                rx_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/codec_serial_port.sv
// Module: codec_serial_port (top)
// Dual-role serial port for 8-bit codec samples. In master mode it makes the
// bit clock and frame strobe itself. In slave mode it follows external ones
// and checks the external clock rate.
// Assumes: clk is the system clock, MASTER_DIV times the master bit-clock rate.
// mode_master is quasi-static, and any change of it aborts the current frame.
module codec_serial_port
    import csp_pkg::*;
#(
    parameter int MASTER_DIV  = 4,
    parameter int FRAME_SLOTS = 256,
    parameter int SYNC_STAGES = 2,
    parameter int RATE_TOL    = 1,
    parameter int WORD_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_master,
    input  logic [1:0]           rate_sel,
    input  logic                 long_frame,
    input  logic                 law_mu,
    input  logic                 bclk_in,
    output logic                 bclk_out,
    output logic                 bclk_oe,
    input  logic                 fs_in,
    output logic                 fs_out,
    input  logic                 sd_in,
    output logic                 sd_out,
    input  logic [WORD_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [WORD_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_mu,
    output logic                 rate_err
);
    bit_evt_t m_evt;
    bit_evt_t s_evt;
    bit_evt_t evt;
    logic     mode_q;
    logic     abort;

    // Role seen on the previous cycle, to catch run-time switches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_master;
        end
    end

    // Role change pulse and event source selection.
    always_comb begin
        abort   = mode_master ^ mode_q;
        evt     = mode_master ? m_evt : s_evt;
        bclk_oe = mode_master;
    end

    csp_master_timing #(
        .MASTER_DIV  (MASTER_DIV),
        .FRAME_SLOTS (FRAME_SLOTS),
        .WORD_BITS   (WORD_BITS)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mode_master),
        .long_frame (long_frame),
        .sd_raw     (sd_in),
        .bclk_q     (bclk_out),
        .fs_q       (fs_out),
        .evt        (m_evt)
    );

    csp_slave_timing #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!mode_master),
        .bclk_in (bclk_in),
        .fs_in   (fs_in),
        .sd_in   (sd_in),
        .evt     (s_evt)
    );

    csp_rate_mon #(
        .MASTER_DIV (MASTER_DIV),
        .RATE_TOL   (RATE_TOL)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!mode_master),
        .rise     (s_evt.rise),
        .rate_sel (rate_sel),
        .rate_err (rate_err)
    );

    csp_frame_engine #(
        .WORD_BITS (WORD_BITS)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .abort    (abort),
        .law_mu   (law_mu),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_mu    (rx_mu),
        .sd_out   (sd_out)
    );

endmodule

// File: rtl/csp_checker.sv
// Module: csp_checker
// Port-level properties of codec_serial_port, attached with bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module csp_checker #(
    parameter int MASTER_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic mode_master,
    input logic bclk_out,
    input logic fs_out,
    input logic sd_out,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rate_err
);
    localparam int KW = $clog2(MASTER_DIV) + 2;

    logic          bclk_d;
    logic          seen_rise;
    logic [KW-1:0] since_rise;
    logic          bclk_rose;

    assign bclk_rose = bclk_out && !bclk_d;

    // Cycles since the last bit-clock rise, while the port stays master.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_master) begin
            bclk_d     <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
        end else begin
            bclk_d <= bclk_out;
            if (bclk_rose) begin
                seen_rise  <= 1'b1;
                since_rise <= KW'(1);
            end else if (since_rise != '1) begin
                since_rise <= since_rise + 1'b1;
            end
        end
    end

    AST_BCLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master && seen_rise && bclk_rose |-> since_rise == KW'(MASTER_DIV)); // R1
    AST_BCLK_QUIET_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |=> !bclk_out); // R1
    AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> !sd_out); // R4
    AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
    AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready); // R6
    AST_NO_STROBE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master && $past(!mode_master) |-> !fs_out); // R7
    AST_NO_RATE_ERR_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master && $past(mode_master) |-> !rate_err); // R9

endmodule

bind codec_serial_port csp_checker #(.MASTER_DIV(MASTER_DIV)) u_csp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .bclk_out    (bclk_out),
    .fs_out      (fs_out),
    .sd_out      (sd_out),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rate_err    (rate_err)
);

// File: tb/sim_codec_serial_port.sv
module sim_codec_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_master = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       long_frame = 1'b0;
    logic       law_mu = 1'b0;
    logic       bclk_in = 1'b0;
    logic       bclk_out;
    logic       bclk_oe;
    logic       fs_in = 1'b0;
    logic       fs_out;
    logic       sd_in = 1'b0;
    logic       sd_out;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_mu;
    logic       rate_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] tx_q[$];
    logic [8:0] rx_q[$];
    logic [7:0] tx_last = 8'h00;
    int half = 16;
    realtime t_start;

    always #4 clk = ~clk;

    codec_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .rate_sel(rate_sel),
        .long_frame(long_frame), .law_mu(law_mu), .bclk_in(bclk_in),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fs_in(fs_in), .fs_out(fs_out),
        .sd_in(sd_in), .sd_out(sd_out), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_mu(rx_mu), .rate_err(rate_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: hands one byte to the port and queues it as expected output.
    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R6 ready drops after accept", tx_ready, 0);
        tx_q.push_back(b);
    endtask

    function automatic logic [7:0] next_tx();
        if (tx_q.size() > 0) tx_last = tx_q.pop_front();
        return tx_last;
    endfunction

    // Monitor: every rx_valid pulse must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_q.size() == 0) begin
                chk(1'b0, "R5 unexpected rx_valid", rx_data, 0);
            end else begin
                logic [8:0] e;
                e = rx_q.pop_front();
                chk({rx_mu, rx_data} == e, "R5 rx word and law", {rx_mu, rx_data}, e);
            end
        end
    end

    // One master frame: checks strobe width, tx bits, idle line; drives rx bits.
    task automatic master_frame(input logic [7:0] rxb, input logic mu, input int fsw_exp);
        logic fsp;
        logic [7:0] got;
        logic [7:0] exp;
        int fsw;
        fsp = 1'b0;
        law_mu = mu;
        rx_q.push_back({mu, rxb});
        forever begin
            @(negedge bclk_out);
            if (fs_out && !fsp) break;
            fsp = fs_out;
        end
        t_start = $realtime;
        exp = next_tx();
        fsw = 1;
        sd_in = rxb[7];
        for (int k = 1; k <= 10; k++) begin
            @(negedge bclk_out);
            fs_in = k[0];                       // noise that must be ignored (R7)
            fsw += int'(fs_out);
            if (k <= 8) begin
                got[8-k] = sd_out;
                sd_in = (k < 8) ? rxb[7-k] : 1'b0;
            end else begin
                chk(sd_out == 1'b0, "R4 line idle after word", sd_out, 0);
            end
        end
        fs_in = 1'b0;
        chk(got == exp, "R4 R6 R7 master tx word", got, exp);
        chk(fsw == fsw_exp, fsw_exp == 1 ? "R2 short strobe width" : "R3 long strobe width", fsw, fsw_exp);
    endtask

    // One slave bit period with the given strobe and data levels.
    task automatic sbit(input logic fs, input logic sd, output logic sdo);
        bclk_in = 1'b1;
        fs_in   = fs;
        sd_in   = sd;
        repeat (half) @(negedge clk);
        sdo = sd_out;
        bclk_in = 1'b0;
        repeat (half) @(negedge clk);
    endtask

    task automatic slave_frame(input logic [7:0] rxb, input logic mu, input logic lng);
        logic o;
        logic [7:0] got;
        logic [7:0] exp;
        law_mu = mu;
        rx_q.push_back({mu, rxb});
        exp = next_tx();
        for (int s = 0; s <= 9; s++) begin
            sbit((s == 0) || (lng && s <= 8), (s >= 1 && s <= 8) ? rxb[8-s] : 1'b0, o);
            if (s >= 1 && s <= 8) got[8-s] = o;
            if (s == 9) chk(o == 1'b0, "R4 slave line idle", o, 0);
        end
        for (int s = 0; s < 3; s++) sbit(1'b0, 1'b0, o);
        chk(got == exp, "R8 slave tx word", got, exp);
    endtask

    task automatic run_bits(input int n);
        logic o;
        for (int s = 0; s < n; s++) sbit(1'b0, 1'b0, o);
    endtask

    initial begin
        realtime t_a;
        repeat (3) @(negedge clk);
        chk(sd_out == 0 && fs_out == 0 && rx_valid == 0 && rate_err == 0, "R11 reset outputs",
            {sd_out, fs_out, rx_valid, rate_err}, 0);
        chk(tx_ready == 1'b1, "R11 reset ready", tx_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        mode_master = 1'b1;
        @(negedge clk);
        chk(bclk_oe == 1'b1, "R1 driver on in master", bclk_oe, 1);

        master_frame(8'hA5, 1'b1, 1);           // resend of reset value 0x00
        t_a = t_start;
        push_tx(8'h3C);
        master_frame(8'h5A, 1'b0, 1);
        chk((t_start - t_a) == 8192.0, "R2 frame period", int'(t_start - t_a), 8192);
        long_frame = 1'b1;
        master_frame(8'h81, 1'b1, 9);           // no push: 0x3C sent again
        push_tx(8'hC3);
        master_frame(8'h18, 1'b0, 9);
        long_frame = 1'b0;
        push_tx(8'hFF);

        // R10: switch role in the middle of an all-ones word.
        begin
            logic fsp;
            fsp = 1'b0;
            forever begin
                @(negedge bclk_out);
                if (fs_out && !fsp) break;
                fsp = fs_out;
            end
            void'(next_tx());
            repeat (4) @(negedge bclk_out);
            chk(sd_out == 1'b1, "R10 word running before switch", sd_out, 1);
            @(negedge clk);
            mode_master = 1'b0;
            repeat (2) @(negedge clk);
            chk(sd_out == 1'b0, "R10 line low after switch", sd_out, 0);
            chk(bclk_oe == 0 && bclk_out == 0, "R1 driver off in slave", {bclk_oe, bclk_out}, 0);
        end

        half = 16;
        rate_sel = 2'b00;
        run_bits(12);                           // no rx_valid may appear (R10)
        slave_frame(8'h7E, 1'b1, 1'b0);         // repeats 0xFF
        chk(fs_out == 1'b0, "R7 no strobe in slave", fs_out, 0);
        push_tx(8'h96);
        slave_frame(8'h18, 1'b0, 1'b1);
        run_bits(3);
        chk(rate_err == 1'b0, "R9 slow rate matches", rate_err, 0);
        rate_sel = 2'b01;
        run_bits(3);
        chk(rate_err == 1'b1, "R9 wrong rate flagged", rate_err, 1);
        rate_sel = 2'b11;
        run_bits(3);
        chk(rate_err == 1'b1, "R9 reserved code flagged", rate_err, 1);
        half = 4;
        rate_sel = 2'b01;
        run_bits(4);
        chk(rate_err == 1'b0, "R9 mid rate matches", rate_err, 0);
        push_tx(8'h0F);
        slave_frame(8'hF0, 1'b1, 1'b0);
        half = 2;
        rate_sel = 2'b10;
        run_bits(5);
        chk(rate_err == 1'b0, "R9 fast rate matches", rate_err, 0);
        rate_sel = 2'b00;
        run_bits(3);
        chk(rate_err == 1'b1, "R9 fast clock vs slow code", rate_err, 1);

        @(negedge clk);
        mode_master = 1'b1;
        repeat (2) @(negedge clk);
        chk(rate_err == 1'b0, "R9 flag clear in master", rate_err, 0);
        master_frame(8'h33, 1'b1, 1);           // 0x0F sent again
        repeat (20) @(negedge clk);
        chk(rx_q.size() == 0, "R5 all rx words delivered", rx_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule